// File: doc/BRIEF.md
# Grayscale PWM Timing Controller

This block turns per-channel grayscale levels into on/off drive for a bank of constant-current channels. It runs on a single grayscale clock. A display period is a full sweep of a `GS_W`-bit counter, which is 65,536 clocks at the default width. Each channel compares its active grayscale level against that counter. Two PWM shapes are available. The conventional shape is a single on-pulse at the start of the period. The spread shape breaks the on-time into many short slices across the period.

Grayscale data arrive as a flat shift-register image and a pending dot-correction vector. Both are copied into active latches when a grayscale-tagged latch strobe rises. The copy happens either on the same clock as the strobe or is deferred to the end of the running display period, so that a period is never torn. A five-bit function-control word selects the behaviour:

- one-shot or repeating display periods;
- whether a grayscale strobe restarts the counter with a blanked clock;
- immediate or deferred data transfer;
- conventional or spread PWM;
- a short-detection threshold select, which the block only passes through.

The sequencer has three states. `ST_IDLE` holds the counter at 0 with all outputs dark. `ST_BLANK` is a single dark clock with the counter at 0. `ST_RUN` counts and drives PWM. The transitions are:

- `IDLE→RUN`: grayscale strobe with timing reset off.
- `IDLE→BLANK` and `RUN→BLANK`: grayscale strobe with timing reset on.
- `BLANK→RUN`: the next clock.
- `BLANK→BLANK`: another strobe with timing reset on.
- `RUN→RUN` (wrap): the last count with repeat on.
- `RUN→IDLE`: the last count with repeat off.

Top module: `gs_pwm_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, `pwm_on` is all 0, `period_active` is 0, `refresh_pending` is 0 and `dc_live` is all 0.
- R2: A clock edge with `fc_wr` high loads `fc_wdata` into the function-control word. The bit map is: bit 0 repeat enable, bit 1 timing-reset enable, bit 2 deferred-refresh enable, bit 3 spread-PWM enable, bit 4 short-threshold select. The word has no reset value. `short_thr_hi` follows bit 4.
- R3: In conventional mode (bit 3 = 0), a channel with level v is on in exactly the period clocks k = 0 .. v−1. It is on for v clocks per period, so level 0 is never on.
- R4: In spread mode (bit 3 = 1), a period is split into 2^SEG_W segments of 2^(GS_W−SEG_W) clocks each. In segment s at offset p, a channel is on when p < (v >> SEG_W) + (s < v mod 2^SEG_W ? 1 : 0). This gives v on-clocks per period.
- R5: With repeat off, the period ends after 2^GS_W running clocks. The block then returns to idle: `period_active` is 0 and outputs stay dark until the next grayscale strobe starts a new period.
- R6: With repeat on, the counter wraps from its maximum to 0 and the next period runs without any strobe.
- R7: With timing reset on, a grayscale strobe forces all outputs off and clears the counter to 0 for one clock. PWM then runs from count 0 on the following clock.
- R8: With timing reset off, a grayscale strobe during a period leaves the counter incrementing without a dark clock.
- R9: With deferred refresh off, a grayscale strobe copies `shift_gs` and `dc_shadow` into the active latches on the strobe's clock edge.
- R10: With deferred refresh on, a grayscale strobe sets `refresh_pending` and leaves the active latches unchanged. Both copies happen on the edge that ends the running period, and `refresh_pending` clears on that edge.
- R11: A strobe is a rising edge of `lat_strobe` with `lat_gs_sel` high. A rising edge with `lat_gs_sel` low changes neither the counter nor the active latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_gs | input | 1 | Grayscale clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_strobe | input | 1 | Latch strobe; acts on its rising edge |
| lat_gs_sel | input | 1 | Tags the strobe as a grayscale write |
| fc_wr | input | 1 | Function-control write enable |
| fc_wdata | input | 5 | Function-control word (map in R2) |
| shift_gs | input | NUM_CH*GS_W | Grayscale image, channel c at bits c*GS_W upward |
| dc_shadow | input | NUM_CH*DC_W | Pending dot-correction vector |
| pwm_on | output | NUM_CH | Per-channel on/off drive |
| dc_live | output | NUM_CH*DC_W | Active dot-correction vector |
| short_thr_hi | output | 1 | Short-detection threshold select |
| refresh_pending | output | 1 | Deferred copy is waiting for the period end |
| period_active | output | 1 | Sequencer is in the running state |

## Verification
- **Full level sweeps.** The bench runs every level of a reduced 8-bit configuration through both PWM shapes. Four channels are driven with levels spaced by a quarter of the range in each period. A per-clock mismatch count separates the conventional pulse from the spread slices. A per-period on-count confirms the total equals the level, including 0 and full scale.
- **Mid-period strobes.** Strobes are injected part-way through a period with timing reset off, with the strobe untagged, and with deferred refresh on. The on-count for the rest of the period then reveals whether the counter restarted, whether the data switched early, or whether the period was torn.
- **Period boundaries.** Back-to-back periods and idle stretches tell the one-shot ending apart from the repeating wrap.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

    localparam int FC_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    // Function-control word; rpt is bit 0, thr_hi is bit 4
    typedef struct packed {
        logic thr_hi;
        logic spread;
        logic defer;
        logic trst;
        logic rpt;
    } fc_t;

endpackage

// File: rtl/gs_pwm_strobe.sv
module gs_pwm_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic lat,
    input  logic gs_sel,
    output logic gs_stb
);

    logic lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
        end else begin
            lat_q <= lat;
        end
    end

    // Rising edge of the strobe, counted only for grayscale writes
    always_comb begin
        gs_stb = lat & ~lat_q & gs_sel;
    end

endmodule

// File: rtl/gs_pwm_seq.sv
module gs_pwm_seq
    import gs_pwm_pkg::*;
#(
    parameter int GS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gs_stb,
    input  logic            rpt,
    input  logic            trst,
    output seq_state_t      state,
    output logic [GS_W-1:0] cnt,
    output logic            period_end
);

    localparam logic [GS_W-1:0] CNT_MAX = '1;

    seq_state_t      state_q, state_d;
    logic [GS_W-1:0] cnt_q, cnt_d;

    // Next-state and next-count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (gs_stb) begin
                    state_d = trst ? ST_BLANK : ST_RUN;
                end
            end
            ST_BLANK: begin
                cnt_d   = '0;
                state_d = (gs_stb && trst) ? ST_BLANK : ST_RUN;
            end
            ST_RUN: begin
                if (gs_stb && trst) begin
                    state_d = ST_BLANK;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_MAX) begin
                    state_d = rpt ? ST_RUN : ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + GS_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        state      = state_q;
        cnt        = cnt_q;
        period_end = (state_q == ST_RUN) && (cnt_q == CNT_MAX);
    end

endmodule

// File: rtl/gs_pwm_bank.sv
module gs_pwm_bank #(
    parameter int NUM_CH = 4,
    parameter int GS_W   = 16,
    parameter int DC_W   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gs_stb,
    input  logic                   defer,
    input  logic                   period_end,
    input  logic [NUM_CH*GS_W-1:0] shift_gs,
    input  logic [NUM_CH*DC_W-1:0] dc_shadow,
    output logic [NUM_CH*GS_W-1:0] gs_live,
    output logic [NUM_CH*DC_W-1:0] dc_live,
    output logic                   pending
);

    logic pend_q, pend_d;
    logic load_now, load_late, do_load;

    always_comb begin
        load_now  = gs_stb & ~defer;
        load_late = pend_q & period_end;
        do_load   = load_now | load_late;
        pend_d    = (gs_stb & defer) | (pend_q & ~period_end);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            gs_live <= '0;
            dc_live <= '0;
        end else begin
            pend_q <= pend_d;
            if (do_load) begin
                gs_live <= shift_gs;
                dc_live <= dc_shadow;
            end
        end
    end

    always_comb begin
        pending = pend_q;
    end

endmodule

// File: rtl/gs_pwm_chan.sv
module gs_pwm_chan #(
    parameter int GS_W  = 16,
    parameter int SEG_W = 7
) (
    input  logic [GS_W-1:0] cnt,
    input  logic [GS_W-1:0] level,
    input  logic            spread,
    input  logic            run,
    output logic            on
);

    localparam int POS_W = GS_W - SEG_W;

    logic [SEG_W-1:0] seg;
    logic [POS_W-1:0] pos;
    logic [POS_W:0]   quota;
    logic             conv_on, spr_on;

    always_comb begin
        seg   = cnt[GS_W-1:POS_W];
        pos   = cnt[POS_W-1:0];
        // Base share from the upper level bits, one extra clock in the first
        // (level mod segment-count) segments
        quota = {1'b0, level[GS_W-1:SEG_W]}
              + {{POS_W{1'b0}}, (seg < level[SEG_W-1:0])};
        conv_on = cnt < level;
        spr_on  = {1'b0, pos} < quota;
        on      = run & (spread ? spr_on : conv_on);
    end

endmodule

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl
    import gs_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int GS_W   = 16,
    parameter int SEG_W  = 7,
    parameter int DC_W   = 7
) (
    input  logic                   clk_gs,
    input  logic                   rst_n,
    input  logic                   lat_strobe,
    input  logic                   lat_gs_sel,
    input  logic                   fc_wr,
    input  logic [FC_W-1:0]        fc_wdata,
    input  logic [NUM_CH*GS_W-1:0] shift_gs,
    input  logic [NUM_CH*DC_W-1:0] dc_shadow,
    output logic [NUM_CH-1:0]      pwm_on,
    output logic [NUM_CH*DC_W-1:0] dc_live,
    output logic                   short_thr_hi,
    output logic                   refresh_pending,
    output logic                   period_active
);

    fc_t                   fc_q;
    logic                  gs_stb;
    seq_state_t            state;
    logic [GS_W-1:0]       cnt_q;
    logic                  period_end;
    logic [NUM_CH*GS_W-1:0] gs_live;

    // Function control: no reset value, must be written before use
    always_ff @(posedge clk_gs) begin
        if (fc_wr) begin
            fc_q <= fc_t'(fc_wdata);
        end
    end

    gs_pwm_strobe u_strobe (
        .clk    (clk_gs),
        .rst_n  (rst_n),
        .lat    (lat_strobe),
        .gs_sel (lat_gs_sel),
        .gs_stb (gs_stb)
    );

    gs_pwm_seq #(.GS_W(GS_W)) u_seq (
        .clk        (clk_gs),
        .rst_n      (rst_n),
        .gs_stb     (gs_stb),
        .rpt        (fc_q.rpt),
        .trst       (fc_q.trst),
        .state      (state),
        .cnt        (cnt_q),
        .period_end (period_end)
    );

    gs_pwm_bank #(.NUM_CH(NUM_CH), .GS_W(GS_W), .DC_W(DC_W)) u_bank (
        .clk        (clk_gs),
        .rst_n      (rst_n),
        .gs_stb     (gs_stb),
        .defer      (fc_q.defer),
        .period_end (period_end),
        .shift_gs   (shift_gs),
        .dc_shadow  (dc_shadow),
        .gs_live    (gs_live),
        .dc_live    (dc_live),
        .pending    (refresh_pending)
    );

    always_comb begin
        period_active = (state == ST_RUN);
        short_thr_hi  = fc_q.thr_hi;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        gs_pwm_chan #(.GS_W(GS_W), .SEG_W(SEG_W)) u_chan (
            .cnt    (cnt_q),
            .level  (gs_live[c*GS_W +: GS_W]),
            .spread (fc_q.spread),
            .run    (period_active),
            .on     (pwm_on[c])
        );
    end

endmodule

// File: rtl/gs_pwm_ctrl_chk.sv
module gs_pwm_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int GS_W   = 16,
    parameter int DC_W   = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lat_strobe,
    input logic                   lat_gs_sel,
    input logic [4:0]             fc_bits,
    input logic [GS_W-1:0]        cnt,
    input logic [NUM_CH-1:0]      pwm_on,
    input logic [NUM_CH*DC_W-1:0] dc_shadow,
    input logic [NUM_CH*DC_W-1:0] dc_live,
    input logic                   refresh_pending,
    input logic                   period_active
);

    logic lat_prev;
    logic stb, last, hard_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) lat_prev <= 1'b0;
        else        lat_prev <= lat_strobe;
    end

    always_comb begin
        stb      = lat_strobe & ~lat_prev & lat_gs_sel;
        last     = period_active && (cnt == '1);
        hard_rst = stb & fc_bits[1];
    end

    p_blank_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> (pwm_on == '0) && (cnt == '0) && !period_active);

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_active && !hard_rst && (cnt != '1)
        |=> period_active && (cnt == $past(cnt) + GS_W'(1)));

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last && !fc_bits[0] && !hard_rst |=> !period_active && (pwm_on == '0));

    p_repeat_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last && fc_bits[0] && !hard_rst |=> period_active && (cnt == '0));

    p_dark_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !period_active |-> (pwm_on == '0));

    p_dc_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stb && !fc_bits[2] |=> dc_live == $past(dc_shadow));

    p_pending_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stb && fc_bits[2] |=> refresh_pending);

    p_dc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && !fc_bits[2]) && !(refresh_pending && last) |=> $stable(dc_live));

    p_pending_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pending && last && !stb |=> !refresh_pending);

endmodule

bind gs_pwm_ctrl gs_pwm_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .GS_W   (GS_W),
    .DC_W   (DC_W)
) u_chk (
    .clk             (clk_gs),
    .rst_n           (rst_n),
    .lat_strobe      (lat_strobe),
    .lat_gs_sel      (lat_gs_sel),
    .fc_bits         (fc_q),
    .cnt             (cnt_q),
    .pwm_on          (pwm_on),
    .dc_shadow       (dc_shadow),
    .dc_live         (dc_live),
    .refresh_pending (refresh_pending),
    .period_active   (period_active)
);

// File: tb/gs_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module gs_pwm_ctrl_tb;

    localparam int NCH = 4;
    localparam int GW  = 8;
    localparam int SW  = 3;
    localparam int DW  = 4;
    localparam int PER = 1 << GW;
    localparam int SEGLEN = PER >> SW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, lat_strobe, lat_gs_sel, fc_wr;
    logic [4:0]        fc_wdata;
    logic [NCH*GW-1:0] shift_gs;
    logic [NCH*DW-1:0] dc_shadow;
    logic [NCH-1:0]    pwm_on;
    logic [NCH*DW-1:0] dc_live;
    logic              short_thr_hi, refresh_pending, period_active;

    gs_pwm_ctrl #(.NUM_CH(NCH), .GS_W(GW), .SEG_W(SW), .DC_W(DW)) u_dut (
        .clk_gs(clk), .rst_n(rst_n), .lat_strobe(lat_strobe), .lat_gs_sel(lat_gs_sel),
        .fc_wr(fc_wr), .fc_wdata(fc_wdata), .shift_gs(shift_gs), .dc_shadow(dc_shadow),
        .pwm_on(pwm_on), .dc_live(dc_live), .short_thr_hi(short_thr_hi),
        .refresh_pending(refresh_pending), .period_active(period_active)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int on_cnt [NCH];
    int miss;
    int cur [NCH];
    bit cur_spread;

    function automatic bit exp_on(int k, int v, bit spr);
        int quota;
        if (!spr) return k < v;
        quota = (v >> SW) + (((k / SEGLEN) < (v % (1 << SW))) ? 1 : 0);
        return (k % SEGLEN) < quota;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NCH; c++) on_cnt[c] = 0;
        miss = 0;
    endtask

    task automatic sample(input int k);
        for (int c = 0; c < NCH; c++) begin
            if (pwm_on[c]) on_cnt[c]++;
            if (pwm_on[c] != exp_on(k, cur[c], cur_spread)) miss++;
        end
    endtask

    task automatic run_from(input int k0, input int k1);
        for (int k = k0; k <= k1; k++) begin
            tick();
            sample(k);
        end
    endtask

    task automatic fc_set(input logic [4:0] w);
        fc_wr = 1'b1;
        fc_wdata = w;
        tick();
        fc_wr = 1'b0;
    endtask

    // Drive a strobe at the current falling edge; returns one clock later
    task automatic strobe(input int v0, input int v1, input int v2, input int v3,
                          input int dc, input bit sel);
        shift_gs[0*GW +: GW] = GW'(v0);
        shift_gs[1*GW +: GW] = GW'(v1);
        shift_gs[2*GW +: GW] = GW'(v2);
        shift_gs[3*GW +: GW] = GW'(v3);
        dc_shadow  = {NCH{DW'(dc)}};
        lat_gs_sel = sel;
        lat_strobe = 1'b1;
        tick();
        lat_strobe = 1'b0;
        lat_gs_sel = 1'b1;
    endtask

    function automatic logic [NCH*DW-1:0] dc_rep(input int dc);
        return {NCH{DW'(dc)}};
    endfunction

    task automatic sweep_period(input int j, input bit spr);
        string rq;
        rq = spr ? "R4" : "R3";
        for (int c = 0; c < NCH; c++) cur[c] = j + 64 * c;
        cur_spread = spr;
        strobe(cur[0], cur[1], cur[2], cur[3], j % 16, 1'b1);
        chk(pwm_on == '0, "R7", int'(pwm_on), 0);
        chk(dc_live == dc_rep(j % 16), "R9", int'(dc_live), int'(dc_rep(j % 16)));
        clear_counts();
        run_from(0, PER - 1);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == cur[c], rq, on_cnt[c], cur[c]);
        chk(miss == 0, rq, miss, 0);
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lat_strobe = 1'b0; lat_gs_sel = 1'b1; fc_wr = 1'b0;
        fc_wdata = '0; shift_gs = '0; dc_shadow = '0;
        cur_spread = 1'b0;
        for (int c = 0; c < NCH; c++) cur[c] = 0;
        @(negedge clk);
        tick();
        // function control written during reset: timing reset on, threshold high
        fc_set(5'b10010);
        chk(pwm_on == '0 && !period_active && !refresh_pending, "R1", int'(pwm_on), 0);
        rst_n = 1'b1;
        tick();
        chk(pwm_on == '0, "R1", int'(pwm_on), 0);
        chk(!period_active, "R1", int'(period_active), 0);
        chk(!refresh_pending, "R1", int'(refresh_pending), 0);
        chk(dc_live == '0, "R1", int'(dc_live), 0);
        chk(short_thr_hi == 1'b1, "R2", int'(short_thr_hi), 1);
        fc_set(5'b00010);
        chk(short_thr_hi == 1'b0, "R2", int'(short_thr_hi), 0);

        // R3: conventional sweep, one-shot, timing reset on
        for (int j = 0; j < 64; j++) sweep_period(j, 1'b0);

        // R5: one-shot period ends and stays dark
        tick();
        chk(!period_active && pwm_on == '0, "R5", int'(period_active), 0);
        begin
            int lit;
            lit = 0;
            for (int i = 0; i < 30; i++) begin
                tick();
                if (period_active || pwm_on != '0) lit++;
            end
            chk(lit == 0, "R5", lit, 0);
        end

        // R4: spread sweep
        fc_set(5'b01010);
        for (int j = 0; j < 64; j++) sweep_period(j, 1'b1);
        tick();

        // R6: repeating periods, conventional, timing reset on
        fc_set(5'b00011);
        cur[0] = 10; cur[1] = 100; cur[2] = 200; cur[3] = 255; cur_spread = 1'b0;
        strobe(cur[0], cur[1], cur[2], cur[3], 7, 1'b1);
        clear_counts();
        run_from(0, PER - 1);
        clear_counts();
        run_from(0, PER - 1);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == cur[c], "R6", on_cnt[c], cur[c]);
        chk(miss == 0, "R6", miss, 0);

        // R8: timing reset off, strobe at count 100
        fc_set(5'b00001);
        run_from(1, 100);
        strobe(120, 120, 120, 120, 5, 1'b1);
        chk(pwm_on == '1 && period_active, "R8", int'(pwm_on), 15);
        chk(dc_live == dc_rep(5), "R9", int'(dc_live), int'(dc_rep(5)));
        for (int c = 0; c < NCH; c++) cur[c] = 120;
        clear_counts();
        run_from(102, 161);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == 18, "R8", on_cnt[c], 18);
        run_from(162, PER - 1);

        // R11: untagged strobe at count 29 is ignored
        run_from(0, 29);
        strobe(0, 0, 0, 0, 9, 1'b0);
        chk(pwm_on == '1, "R11", int'(pwm_on), 15);
        chk(dc_live == dc_rep(5), "R11", int'(dc_live), int'(dc_rep(5)));
        clear_counts();
        run_from(31, PER - 1);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == 89, "R11", on_cnt[c], 89);

        // R10: deferred refresh, strobe at count 49
        fc_set(5'b00101);
        run_from(1, 49);
        strobe(30, 60, 90, 250, 12, 1'b1);
        chk(refresh_pending == 1'b1, "R10", int'(refresh_pending), 1);
        chk(dc_live == dc_rep(5), "R10", int'(dc_live), int'(dc_rep(5)));
        clear_counts();
        sample(50);
        run_from(51, PER - 1);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == 70, "R10", on_cnt[c], 70);
        tick();
        chk(refresh_pending == 1'b0, "R10", int'(refresh_pending), 0);
        chk(dc_live == dc_rep(12), "R10", int'(dc_live), int'(dc_rep(12)));
        cur[0] = 30; cur[1] = 60; cur[2] = 90; cur[3] = 250;
        clear_counts();
        sample(0);
        run_from(1, PER - 1);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == cur[c], "R10", on_cnt[c], cur[c]);
        chk(miss == 0, "R10", miss, 0);

        // R7: timing reset on, strobe at count 79 restarts the period
        fc_set(5'b00011);
        run_from(1, 79);
        strobe(5, 5, 5, 5, 3, 1'b1);
        chk(pwm_on == '0 && !period_active, "R7", int'(pwm_on), 0);
        for (int c = 0; c < NCH; c++) cur[c] = 5;
        clear_counts();
        run_from(0, PER - 1);
        for (int c = 0; c < NCH; c++) chk(on_cnt[c] == 5, "R7", on_cnt[c], 5);
        chk(miss == 0, "R7", miss, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule